// File: doc/BRIEF.md
# Fault Status Capture Unit

This block sits beside a processor core and turns raw memory-access fault reports into a sticky status record. For each fault report, the core gives a strobe, a flag that tells an instruction fetch from a data access, a short fault code and the faulting address. The unit sorts every report into one of two classes: a memory-protection fault or a bus fault. It then ORs the matching status bits into a status register. For data-side faults only, it also stores the address in the address register of that class.

Each classified fault also raises a one-cycle pending pulse towards the interrupt controller, on either the protection output or the bus output. Software reads the status register and the two address registers through a small word-addressed register port, and clears status bits by writing ones to them. The protection checks, exception priority, stacking and vector fetch are all handled elsewhere.

Top module: `fsc_unit`

## Requirements
- R1: Only bits [3:0] of `flt_code` are decoded. The value 4'h8 classifies a fault as a bus fault, and any higher code bits have no effect on the class.
- R2: Every value of `flt_code[3:0]` other than 4'h8 classifies the fault as a memory-protection fault.
- R3: A protection fault with `flt_is_data`=0 sets status bit 0 (instruction access violation) and leaves both address registers unchanged.
- R4: A protection fault with `flt_is_data`=1 sets status bit 1 (data access violation) and bit 2 (protection address valid), and loads `flt_addr` into the protection address register.
- R5: A bus fault with `flt_is_data`=1 sets status bit 9 (data bus error) and bit 10 (bus address valid), and loads `flt_addr` into the bus address register.
- R6: A bus fault with `flt_is_data`=0 sets status bit 8 (instruction bus error) only and leaves both address registers unchanged.
- R7: Status bits are sticky: a later fault adds its bits and never removes bits that an earlier fault set.
- R8: Writing word 0 clears each status bit whose write-data bit is 1. Clearing a valid bit leaves the address registers unchanged. Writes to words 1, 2 and 3 have no effect.
- R9: A fault strobed in cycle N gives a single-cycle high on `prot_pend` or `bus_pend` (never both) in cycle N+1. This is the same cycle in which the status register shows the new bits.
- R10: When a word-0 write clears a bit in the same cycle that a fault sets it, the bit ends up set.
- R11: After reset, all three registers read zero and both pending outputs are low.
- R12: A data fault whose class already has its address-valid bit set overwrites the address register with the newest address.
- R13: The read data follows `reg_addr` in the same cycle. Word 0 is the status register, word 1 the protection address, word 2 the bus address, and word 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault report strobe, one per cycle |
| flt_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| flt_code | input | CODE_W | Fault code; only bits [3:0] are decoded |
| flt_addr | input | ADDR_W | Faulting address |
| reg_addr | input | 2 | Register word select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data (ones clear status bits) |
| reg_rdata | output | DATA_W | Read data for the selected word |
| prot_pend | output | 1 | Protection fault pending pulse |
| bus_pend | output | 1 | Bus fault pending pulse |

## Verification
The bench builds the unit with CODE_W=8 and leaves the other parameters at their defaults. With CODE_W=8, codes such as 8'h18 and 8'hF3 can be driven, so the test shows that only the low nibble decides the class. The combinational read path (READ_LAT=0) lets the bench compare the selected register against its model in every cycle. It also sweeps all sixteen low-nibble codes on both sides and checks the set-versus-clear collision.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   // status register bit positions
   localparam int unsigned IVIOL_B  = 0;
   localparam int unsigned DVIOL_B  = 1;
   localparam int unsigned PVALID_B = 2;
   localparam int unsigned IBERR_B  = 8;
   localparam int unsigned DBERR_B  = 9;
   localparam int unsigned BVALID_B = 10;
   localparam int unsigned STAT_W   = 11;

   // address register slots
   localparam int unsigned CAP_PROT = 0;
   localparam int unsigned CAP_BUS  = 1;
   localparam int unsigned N_CAP    = 2;

   typedef enum logic [1:0] {
      RA_STATUS = 2'd0,
      RA_PADDR  = 2'd1,
      RA_BADDR  = 2'd2,
      RA_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/fsc_classify.sv
module fsc_classify
   import fsc_pkg::*;
#(
   parameter int unsigned CODE_W   = 4,
   parameter logic [3:0]  BUS_CODE = 4'h8
) (
   input  logic                 valid_i,
   input  logic                 is_data_i,
   input  logic [CODE_W-1:0]    code_i,
   output logic [STAT_W-1:0]    set_o,
   output logic [N_CAP-1:0]     cap_o,
   output logic                 prot_o,
   output logic                 bus_o
);
   logic is_bus;
   assign is_bus = (code_i[3:0] == BUS_CODE);

   always_comb begin
      set_o  = '0;
      cap_o  = '0;
      prot_o = 1'b0;
      bus_o  = 1'b0;
      if (valid_i) begin
         if (is_bus) begin
            bus_o = 1'b1;
            if (is_data_i) begin
               set_o[DBERR_B]  = 1'b1;
               set_o[BVALID_B] = 1'b1;
               cap_o[CAP_BUS]  = 1'b1;
            end else begin
               set_o[IBERR_B]  = 1'b1;
            end
         end else begin
            prot_o = 1'b1;
            if (is_data_i) begin
               set_o[DVIOL_B]  = 1'b1;
               set_o[PVALID_B] = 1'b1;
               cap_o[CAP_PROT] = 1'b1;
            end else begin
               set_o[IVIOL_B]  = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fsc_status_reg.sv
module fsc_status_reg #(
   parameter int unsigned W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);
   logic [W-1:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_i) | set_i;
   end

   assign stat_o = stat_q;

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i))); // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(set_i)) == $past(set_i))); // R10
endmodule

// File: rtl/fsc_addr_reg.sv
module fsc_addr_reg #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr_q <= '0;
      else if (cap_i) addr_q <= addr_i;
   end

   assign addr_o = addr_q;

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(addr_q)); // R8
   AST_ADDR_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (addr_q == $past(addr_i))); // R12
endmodule

// File: rtl/fsc_unit.sv
module fsc_unit
   import fsc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned READ_LAT  = 0,
   parameter logic [3:0]  BUS_CODE  = 4'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_valid,
   input  logic              flt_is_data,
   input  logic [CODE_W-1:0] flt_code,
   input  logic [ADDR_W-1:0] flt_addr,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              prot_pend,
   output logic              bus_pend
);
   if (CODE_W < 4) begin : g_bad_code
      $error("fsc_unit: CODE_W must be at least 4");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("fsc_unit: ADDR_W must not exceed DATA_W");
   end
   if (DATA_W < STAT_W) begin : g_bad_data
      $error("fsc_unit: DATA_W too narrow for status");
   end
   if (READ_LAT > 1) begin : g_bad_lat
      $error("fsc_unit: READ_LAT must be 0 or 1");
   end

   logic [STAT_W-1:0] set_mask, clr_mask, stat;
   logic [N_CAP-1:0]  cap;
   logic              prot_c, bus_c;
   logic              prot_q, bus_q;
   logic [ADDR_W-1:0] addr_q [N_CAP];
   logic [DATA_W-1:0] rd_c;

   fsc_classify #(.CODE_W(CODE_W), .BUS_CODE(BUS_CODE)) u_cls (
      .valid_i  (flt_valid),
      .is_data_i(flt_is_data),
      .code_i   (flt_code),
      .set_o    (set_mask),
      .cap_o    (cap),
      .prot_o   (prot_c),
      .bus_o    (bus_c)
   );

   assign clr_mask = (reg_wr && reg_addr == RA_STATUS) ? reg_wdata[STAT_W-1:0] : '0;

   fsc_status_reg #(.W(STAT_W)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_mask),
      .clr_i (clr_mask),
      .stat_o(stat)
   );

   for (genvar gi = 0; gi < N_CAP; gi++) begin : g_addr
      fsc_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
         .clk   (clk),
         .rst_n (rst_n),
         .cap_i (cap[gi]),
         .addr_i(flt_addr),
         .addr_o(addr_q[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q <= 1'b0;
         bus_q  <= 1'b0;
      end else begin
         prot_q <= prot_c;
         bus_q  <= bus_c;
      end
   end
   assign prot_pend = prot_q;
   assign bus_pend  = bus_q;

   always_comb begin
      unique case (reg_addr)
         RA_STATUS: rd_c = DATA_W'(stat);
         RA_PADDR:  rd_c = DATA_W'(addr_q[CAP_PROT]);
         RA_BADDR:  rd_c = DATA_W'(addr_q[CAP_BUS]);
         default:   rd_c = '0;
      endcase
   end

   if (READ_LAT == 0) begin : g_rd_comb
      assign reg_rdata = rd_c;
   end else begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_c;
      end
      assign reg_rdata = rd_q;
   end

   AST_PEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(prot_pend && bus_pend)); // R9
   AST_BUS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && flt_code[3:0] == BUS_CODE) |=> (bus_pend && !prot_pend)); // R1
   AST_PROT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && flt_code[3:0] != BUS_CODE) |=> (prot_pend && !bus_pend)); // R2
   AST_NO_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_valid |=> (!prot_pend && !bus_pend)); // R9
   AST_PADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && flt_is_data && flt_code[3:0] != BUS_CODE)
      |=> (addr_q[CAP_PROT] == $past(flt_addr))); // R4
   AST_BADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && flt_is_data && flt_code[3:0] == BUS_CODE)
      |=> (addr_q[CAP_BUS] == $past(flt_addr))); // R5
   AST_IFETCH_NOCAP: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !flt_is_data)
      |=> ($stable(addr_q[CAP_PROT]) && $stable(addr_q[CAP_BUS]))); // R3 R6
endmodule

// File: tb/fsc_unit_bench.sv
`timescale 1ns/1ps
module fsc_unit_bench;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flt_valid = 1'b0;
   logic          flt_is_data = 1'b0;
   logic [CW-1:0] flt_code = '0;
   logic [31:0]   flt_addr = '0;
   logic [1:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          prot_pend, bus_pend;

   always #2.5 clk = ~clk;

   fsc_unit #(.CODE_W(CW)) u_fsc_unit (
      .clk(clk), .rst_n(rst_n),
      .flt_valid(flt_valid), .flt_is_data(flt_is_data),
      .flt_code(flt_code), .flt_addr(flt_addr),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .prot_pend(prot_pend), .bus_pend(bus_pend)
   );

   // behavioural reference state
   logic [31:0] m_stat = '0, m_pa = '0, m_ba = '0;
   logic        m_pp = 1'b0, m_bp = 1'b0;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   function automatic logic [31:0] m_read(input logic [1:0] a);
      case (a)
         2'd0: return m_stat;
         2'd1: return m_pa;
         2'd2: return m_ba;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, update model at posedge, compare at next negedge
   task automatic step(input string tag, input bit fv, input bit isd, input logic [CW-1:0] code,
                       input logic [31:0] addr, input logic [1:0] ra, input bit wr,
                       input logic [31:0] wd);
      logic [31:0] set;
      logic [31:0] clr;
      flt_valid = fv; flt_is_data = isd; flt_code = code; flt_addr = addr;
      reg_addr = ra; reg_wr = wr; reg_wdata = wd;
      @(posedge clk);
      set = 0; m_pp = 0; m_bp = 0;
      clr = (wr && ra == 2'd0) ? wd : 32'h0;
      if (fv) begin
         if (code[3:0] == 4'h8) begin
            m_bp = 1;
            if (isd) begin set = (32'h1 << 9) | (32'h1 << 10); m_ba = addr; end
            else set = 32'h1 << 8;
         end else begin
            m_pp = 1;
            if (isd) begin set = 32'h6; m_pa = addr; end
            else set = 32'h1;
         end
      end
      m_stat = (m_stat & ~clr) | set;
      @(negedge clk);
      chk({tag, " prot_pend R9"}, 32'(prot_pend), 32'(m_pp));
      chk({tag, " bus_pend R9"},  32'(bus_pend),  32'(m_bp));
      chk({tag, " rdata R13"},    reg_rdata,      m_read(ra));
   endtask

   task automatic idle(input string tag, input logic [1:0] ra);
      step(tag, 0, 0, '0, 32'h0, ra, 0, 32'h0);
   endtask

   task automatic read_all(input string tag);
      for (int a = 0; a < 4; a++) idle(tag, 2'(a));
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 prot_pend in reset", 32'(prot_pend), 0);
      chk("R11 rdata in reset", reg_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      read_all("R11");

      // R3 R2: protection fault on fetch
      step("R3 ifetch prot", 1, 0, 8'h00, 32'hAAAA_0000, 2'd0, 0, 0);
      read_all("R3");
      // R4: protection fault on data
      step("R4 data prot", 1, 1, 8'h03, 32'h1234_5678, 2'd1, 0, 0);
      read_all("R4");
      // R5 R1: bus fault on data
      step("R5 data bus", 1, 1, 8'h08, 32'hCAFE_0004, 2'd2, 0, 0);
      read_all("R5");
      // R6 R1: bus fault on fetch, upper code bits set
      step("R6 ifetch bus hi-bits R1", 1, 0, 8'h18, 32'hDEAD_BEEF, 2'd0, 0, 0);
      read_all("R6");
      // R12 R7: newer data protection fault overwrites address, bits stay
      step("R12 overwrite", 1, 1, 8'hF3, 32'h0BAD_F00D, 2'd1, 0, 0);
      read_all("R12 R7");
      // R8: clear protection valid bit, address unchanged
      step("R8 w1c valid", 0, 0, '0, 0, 2'd0, 1, 32'h4);
      read_all("R8");
      // R8: writes to address words ignored
      step("R8 write word1", 0, 0, '0, 0, 2'd1, 1, 32'hFFFF_FFFF);
      step("R8 write word2", 0, 0, '0, 0, 2'd2, 1, 32'hFFFF_FFFF);
      step("R8 write word3", 0, 0, '0, 0, 2'd3, 1, 32'hFFFF_FFFF);
      read_all("R8 ignored");
      // R10: clear and set of the same bits in one cycle
      step("R10 collide", 1, 1, 8'h01, 32'h5555_0000, 2'd0, 1, 32'h6);
      read_all("R10");
      // R9: back-to-back faults of alternating class
      step("R9 b2b a", 1, 1, 8'h08, 32'h1000_0000, 2'd2, 0, 0);
      step("R9 b2b b", 1, 0, 8'h02, 32'h2000_0000, 2'd0, 0, 0);
      step("R9 b2b c", 1, 1, 8'h48, 32'h3000_0000, 2'd2, 0, 0);
      idle("R9 tail", 2'd0);
      // R1 R2: sweep all codes on both sides, clearing between
      for (int c = 0; c < 32; c++) begin
         step("R1 R2 sweep clr", 0, 0, '0, 0, 2'd0, 1, 32'hFFFF_FFFF);
         step("R1 R2 sweep", 1, c[0], 8'(c >> 1) | 8'h30, 32'h4000_0000 + 32'(c), 2'd0, 0, 0);
         idle("R1 R2 sweep pa", 2'd1);
         idle("R1 R2 sweep ba", 2'd2);
      end
      // R8: clear everything
      step("R8 clear all", 0, 0, '0, 0, 2'd0, 1, 32'hFFFF_FFFF);
      read_all("R8 R13 final");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule